// File: doc/BRIEF.md
# I2C Register Control Port

This block is an I2C target that gives a host access to a small bank of 8-bit configuration registers over two wires. SCL is an input only. SDA is handled as an open-drain pair: the block reads the line through `sda_i` and pulls it low by raising `sda_oe`. Both bus inputs are re-timed to the system clock by two-flop synchronisers. START, STOP and SCL edge events are then derived from the synchronised copies.

Every transfer begins with a chip address byte. Its upper five bits are fixed, the next two bits come from strap pins, and its least significant bit selects write or read. In a write, the byte after the address loads the register pointer and the auto-advance flag. Any further bytes are stored starting at the pointer. A read streams registers out from the current pointer until the host answers a byte with NACK. The pointer keeps its value across transactions, so a host usually sets it with a short write and then reads with a repeated START.

Top module: `ctl_port_i2c`

## Requirements
- R1: The block acknowledges an address byte equal to {1,0,0,1,0, strap_a1, strap_a0, rw}, sent MSB first with rw as bit 0. It acknowledges by holding SDA low for the whole ninth SCL clock.
- R2: A START (SDA falls while SCL is high) begins a new address phase from any state, including a repeated START in mid-transaction. A STOP (SDA rises while SCL is high) returns the block to idle with SDA released.
- R3: `sda_oe` changes only after an SCL falling edge, START or STOP, so the block never moves SDA while SCL is high.
- R4: In a write, the byte after the address is the pointer byte and is acknowledged. Bit 7 is the auto-advance flag. Bits [IDX_W-1:0] give the register index (16 registers by default), and any higher index bits are ignored.
- R5: Each data byte after the pointer byte is stored at the pointer and acknowledged. With the flag set, the pointer then advances and wraps from the last register to register 0. With the flag clear, the pointer holds, so a later byte overwrites the earlier one.
- R6: A read returns the register at the pointer, MSB first. The pointer set in an earlier transaction is kept. With the flag set, the pointer advances after every byte sent, including the last one.
- R7: After the host NACKs a read byte, the block leaves SDA released until the next START or STOP.
- R8: If the address byte does not match, the block does not acknowledge and writes nothing. It stays silent until the next START.
- R9: After reset every register reads 0x00, SDA is released, the pointer is 0 and auto-advance is off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen on the wire (asynchronous) |
| sda_oe | output | 1 | High pulls SDA low |
| strap_a1 | input | 1 | Address strap, address bit 2 |
| strap_a0 | input | 1 | Address strap, address bit 1 |

## Verification
The bench writes with the flag clear and then reads the same register twice. A design that advanced anyway would return the neighbour's value. It fills the last register and runs on into register 0, which catches a pointer that stops at the top or spills beyond the bank. It sends addresses that are wrong only in the strap bits, and others that are wrong only in the fixed bits, then follows each with data. A loose address compare would then acknowledge or write a register. It also reads past a host NACK and reads again in a fresh transaction with no pointer byte. A slave that kept driving would corrupt those bytes, and a pointer that failed to advance on the last byte would return the wrong register.

// File: rtl/ctlp_pkg.sv
// Shared types for the register control port.
package ctlp_pkg;
    // Protocol phase of the target engine
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_MAP,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } ctlp_state_e;
endpackage

// File: rtl/ctlp_sync.sv
// Two-flop synchroniser per bit for asynchronous bus inputs.
// Assumes each bit is independent; no cross-bit coherence is promised.
module ctlp_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, sync_q;
        // Re-time one bit through two stages; idle bus level is high
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
            end else begin
                meta_q <= d_async[i];
                sync_q <= meta_q;
            end
        end
        assign d_sync[i] = sync_q;
    end
endmodule

// File: rtl/ctlp_bus_events.sv
// Derives START, STOP and SCL edge strobes from synchronised SCL/SDA.
// Assumes both inputs went through synchronisers of equal latency.
module ctlp_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_ev,
    output logic stop_ev,
    output logic rise_ev,
    output logic fall_ev
);
    logic scl_d, sda_d;

    // Hold the previous sample of each line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
    assign rise_ev  = scl_s & ~scl_d;
    assign fall_ev  = ~scl_s & scl_d;
endmodule

// File: rtl/ctlp_regfile.sv
// Register bank: one synchronous write port, one combinational read port.
// Assumes the index is already limited to IDX_W bits; resets to zero.
module ctlp_regfile #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Clear on reset, otherwise store one byte when enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/ctlp_engine.sv
// Byte-level target state machine: address match, pointer byte, data
// write/read with optional pointer advance, ACK drive and host ACK sampling.
// Assumes single-cycle event strobes from ctlp_bus_events; no clock stretching.
module ctlp_engine
    import ctlp_pkg::*;
#(
    parameter int         IDX_W  = 4,
    parameter logic [4:0] DEV_ID = 5'b10010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             start_ev,
    input  logic             stop_ev,
    input  logic             rise_ev,
    input  logic             fall_ev,
    input  logic             strap_a1,
    input  logic             strap_a0,
    input  logic [7:0]       rd_data,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic             sda_oe
);
    localparam logic [IDX_W-1:0] PTR_ONE = IDX_W'(1);
    localparam logic [3:0]       BYTE_END = 4'd8;

    ctlp_state_e      state, nxt;
    logic [7:0]       shreg, tx;
    logic [3:0]       bitcnt;
    logic [IDX_W-1:0] ptr;
    logic             incr, rd_go, oe;
    logic             byte_done;

    assign byte_done = fall_ev && (bitcnt == BYTE_END);
    assign wr_en     = (state == ST_WDATA) && byte_done;
    assign wr_idx    = ptr;
    assign wr_data   = shreg;
    assign rd_idx    = ptr;
    assign sda_oe    = oe;

    // Sequence the bus protocol one event at a time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            nxt    <= ST_IDLE;
            shreg  <= '0;
            tx     <= '0;
            bitcnt <= '0;
            ptr    <= '0;
            incr   <= 1'b0;
            rd_go  <= 1'b0;
            oe     <= 1'b0;
        end else if (start_ev) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
            oe     <= 1'b0;
        end else if (stop_ev) begin
            state <= ST_IDLE;
            oe    <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_MAP, ST_WDATA: begin
                    if (rise_ev && bitcnt < BYTE_END) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        if (state == ST_ADDR) begin
                            if (shreg[7:1] == {DEV_ID, strap_a1, strap_a0}) begin
                                oe    <= 1'b1;
                                state <= ST_ACK;
                                nxt   <= shreg[0] ? ST_RDATA : ST_MAP;
                                tx    <= rd_data;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end else if (state == ST_MAP) begin
                            ptr   <= shreg[IDX_W-1:0];
                            incr  <= shreg[7];
                            oe    <= 1'b1;
                            state <= ST_ACK;
                            nxt   <= ST_WDATA;
                        end else begin
                            if (incr) ptr <= ptr + PTR_ONE;
                            oe    <= 1'b1;
                            state <= ST_ACK;
                            nxt   <= ST_WDATA;
                        end
                    end
                end
                ST_ACK: begin
                    if (fall_ev) begin
                        state  <= nxt;
                        bitcnt <= '0;
                        oe     <= (nxt == ST_RDATA) ? ~tx[7] : 1'b0;
                    end
                end
                ST_RDATA: begin
                    if (rise_ev) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (fall_ev) begin
                        if (bitcnt == BYTE_END) begin
                            oe    <= 1'b0;
                            state <= ST_RACK;
                        end else begin
                            oe <= ~tx[3'd7 - bitcnt[2:0]];
                        end
                    end
                end
                ST_RACK: begin
                    if (rise_ev) begin
                        rd_go <= ~sda_s;
                        if (incr) ptr <= ptr + PTR_ONE;
                    end else if (fall_ev) begin
                        if (rd_go) begin
                            state  <= ST_RDATA;
                            bitcnt <= '0;
                            tx     <= rd_data;
                            oe     <= ~rd_data[7];
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ctl_port_i2c.sv
// Top of the I2C register control port: synchronisers, bus event
// detection, protocol engine and register bank.
// Assumes an external pull-up on SDA; sda_oe high means drive low.
module ctl_port_i2c #(
    parameter int         IDX_W  = 4,
    parameter logic [4:0] DEV_ID = 5'b10010
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    input  logic strap_a1,
    input  logic strap_a0
);
    logic             scl_s, sda_s;
    logic             start_ev, stop_ev, rise_ev, fall_ev;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [7:0]       wr_data, rd_data;

    ctlp_sync #(.W(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({scl_i, sda_i}),
        .d_sync  ({scl_s, sda_s})
    );

    ctlp_bus_events u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .rise_ev  (rise_ev),
        .fall_ev  (fall_ev)
    );

    ctlp_engine #(.IDX_W(IDX_W), .DEV_ID(DEV_ID)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (sda_s),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .rise_ev  (rise_ev),
        .fall_ev  (fall_ev),
        .strap_a1 (strap_a1),
        .strap_a0 (strap_a0),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .sda_oe   (sda_oe)
    );

    ctlp_regfile #(.IDX_W(IDX_W), .DATA_W(8)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/ctlp_checker.sv
// Protocol checks for ctl_port_i2c, attached by bind below.
// Assumes the engine state and pointer are visible through the bind.
module ctlp_checker
    import ctlp_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sda_oe,
    input logic             start_ev,
    input logic             stop_ev,
    input logic             fall_ev,
    input ctlp_state_e      state,
    input logic [IDX_W-1:0] ptr,
    input logic             incr,
    input logic [3:0]       bitcnt
);
    AST_OE_MOVES_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> $past(fall_ev || start_ev || stop_ev)); // R3

    AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_ev) |-> (state == ST_ADDR && !sda_oe && bitcnt == 4'd0)); // R2

    AST_SILENT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE || state == ST_IDLE) |-> !sda_oe); // R8

    AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(incr) && $past(state) != ST_MAP) |-> $stable(ptr)); // R5

    AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= 4'd8); // R1
endmodule

bind ctl_port_i2c ctlp_checker #(.IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .fall_ev  (fall_ev),
    .state    (u_eng.state),
    .ptr      (u_eng.ptr),
    .incr     (u_eng.incr),
    .bitcnt   (u_eng.bitcnt)
);

// File: tb/tb_ctl_port_i2c.sv
// Scoreboard bench: bus driver tasks queue expected bytes/ACK bits,
// a monitor process compares them with what the bus returns.
module tb_ctl_port_i2c;
    localparam int Q = 6;   // system clocks per quarter SCL period

    typedef struct {
        string      tag;
        logic [7:0] val;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    int   checks = 0;
    int   errors = 0;
    item_t exp_q[$];
    item_t act_q[$];

    always #10 clk = ~clk;   // 50 MHz

    assign sda_line = sda_m & ~sda_oe;

    ctl_port_i2c dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .strap_a1 (1'b1),
        .strap_a0 (1'b0)
    );

    // Monitor: pair produced items with expected ones in order
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0 && act_q.size() > 0) begin
                item_t e;
                item_t a;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                checks++;
                if (a.val !== e.val) begin
                    errors++;
                    $display("FAIL %s: actual %02h expected %02h", e.tag, a.val, e.val);
                end
            end
        end
    end

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait(); qwait();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; qwait();
        scl_m = 1'b1; qwait(); qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        b = sda_line; qwait();
        scl_m = 1'b0; qwait();
    endtask

    // Driver: send a byte, expect ACK (line low) or NACK (line high)
    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
        logic ack;
        exp_q.push_back('{tag, {7'd0, ~exp_ack}});
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(ack);
        act_q.push_back('{tag, {7'd0, ack}});
    endtask

    // Driver: receive a byte, then answer ACK or NACK
    task automatic recv_byte(input logic [7:0] exp, input bit host_ack, input string tag);
        logic [7:0] v;
        exp_q.push_back('{tag, exp});
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        act_q.push_back('{tag, v});
        put_bit(~host_ack);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        checks++;   // R9 SDA released after reset
        if (sda_oe !== 1'b0) begin
            errors++;
            $display("FAIL R9 reset oe: actual %b expected 0", sda_oe);
        end

        // Advancing write to registers 2..4
        bus_start();
        send_byte(8'h94, 1, "R1 R3 address write ack");
        send_byte(8'h82, 1, "R4 pointer byte ack");
        send_byte(8'hA1, 1, "R5 data ack");
        send_byte(8'hB2, 1, "R5 data ack");
        send_byte(8'hC3, 1, "R5 data ack");
        bus_stop();

        // Holding pointer: repeated reads of register 3
        bus_start();
        send_byte(8'h94, 1, "R1 address ack");
        send_byte(8'h03, 1, "R4 pointer hold ack");
        bus_start();
        send_byte(8'h95, 1, "R2 repeated start read ack");
        recv_byte(8'hB2, 1, "R6 read at pointer");
        recv_byte(8'hB2, 0, "R5 pointer holds on read");
        bus_stop();

        // Holding pointer write overwrites; untouched register is zero
        bus_start();
        send_byte(8'h94, 1, "R1 address ack");
        send_byte(8'h05, 1, "R4 pointer ack");
        send_byte(8'h11, 1, "R5 data ack");
        send_byte(8'h22, 1, "R5 data ack");
        bus_stop();
        bus_start();
        send_byte(8'h94, 1, "R1 address ack");
        send_byte(8'h85, 1, "R4 pointer ack");
        bus_start();
        send_byte(8'h95, 1, "R2 read ack");
        recv_byte(8'h22, 1, "R5 overwrite without advance");
        recv_byte(8'h00, 0, "R9 untouched register zero");
        bus_stop();

        // Address mismatch in strap bits, then in fixed bits
        bus_start();
        send_byte(8'h92, 0, "R8 strap mismatch nack");
        send_byte(8'h82, 0, "R8 ignored pointer");
        send_byte(8'h55, 0, "R8 ignored data");
        bus_start();
        send_byte(8'h94, 1, "R2 restart after mismatch");
        send_byte(8'h02, 1, "R4 pointer ack");
        bus_stop();
        bus_start();
        send_byte(8'h14, 0, "R8 fixed bits mismatch nack");
        send_byte(8'h66, 0, "R8 ignored data");
        bus_stop();
        bus_start();
        send_byte(8'h95, 1, "R1 read ack");
        recv_byte(8'hA1, 0, "R8 register untouched");
        bus_stop();

        // Wrap from last register, NACK release, pointer persistence
        bus_start();
        send_byte(8'h94, 1, "R1 address ack");
        send_byte(8'h8F, 1, "R4 pointer last register");
        send_byte(8'h5A, 1, "R5 data ack");
        send_byte(8'h6B, 1, "R5 wrap data ack");
        send_byte(8'h7C, 1, "R5 data ack");
        bus_stop();
        bus_start();
        send_byte(8'h94, 1, "R1 address ack");
        send_byte(8'h8F, 1, "R4 pointer ack");
        bus_start();
        send_byte(8'h95, 1, "R2 read ack");
        recv_byte(8'h5A, 1, "R6 read last register");
        recv_byte(8'h6B, 0, "R5 wrap to register 0");
        recv_byte(8'hFF, 0, "R7 released after nack");
        bus_stop();
        bus_start();
        send_byte(8'h95, 1, "R1 read ack");
        recv_byte(8'h7C, 0, "R6 pointer advanced past last byte");
        bus_stop();

        repeat (10) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule